// File: doc/BRIEF.md
# Sampled Event-Input Glitch Filter

This block cleans up an external pulse line before it reaches an event counter. The raw line first passes through a two-flop synchroniser. In filtered mode, a change of level is then passed to the output only after the new level has stayed in place across a set number of falling edges of a slow sampling clock. The default is two edges. Any excursion that ends before that many edges is dropped. The sampling clock arrives as a one-cycle enable pulse in the system clock domain, one pulse for each of its falling edges.

Filtering applies only when the filter-enable input and the event-mode input are both high. In every other case the output is the synchronised raw line. With a 2048 Hz sampling clock, the filter always rejects pulses shorter than one sampling period (about 0.49 ms). It always passes pulses of two periods (about 0.98 ms) or longer. The output idles high and comes out of reset high, so the edge detector downstream sees no edge at reset.

There is no data stream here, only level signals, so there is no valid/ready handshake. Every pin is a plain control or level signal.

Top module: `evt_glitch_filter`

## Requirements
- R1: In filtered mode (filt_en=1 and evt_mode=1), a level change on raw_in reaches filt_out on the second samp_fall pulse that is sampled while the synchronised level differs from filt_out. The synchronised level at clock edge k equals raw_in at edge k-2. filt_out changes on that same clock edge.
- R2: In filtered mode, if the synchronised level returns to filt_out before the second such pulse, the pending count clears and filt_out does not change. An excursion that covers a single pulse cannot be combined with a later single-pulse excursion.
- R3: In filtered mode, with samp_fall pulsing every SP clock cycles, a low pulse shorter than SP cycles never changes filt_out. A low pulse of 2*SP cycles or more always changes it.
- R4: With filt_en=0, filt_out equals raw_in delayed by exactly two clock cycles: raw_in sampled at edge k shows on filt_out after edge k+1. samp_fall has no effect.
- R5: With evt_mode=0, filt_en has no effect and filt_out follows the two-cycle-delayed raw_in exactly as in R4.
- R6: While rst_n is low, filt_out is 1 whatever the level of raw_in, and the pending count is 0.
- R7: In filtered mode, the return from low to high is filtered in the same way as the fall. It appears on the second samp_fall pulse that sees the high synchronised level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_fall | input | 1 | One-cycle pulse for each falling edge of the sampling clock |
| raw_in | input | 1 | Unsynchronised external pulse input, idle high |
| filt_en | input | 1 | 1 selects the glitch filter when in event mode |
| evt_mode | input | 1 | 1 when the following counter is in event-counting mode |
| filt_out | output | 1 | Filtered (or bypassed) level for the edge detector |

## Verification
In filtered mode, the main sweep drives single low pulses of every length from 1 to 24 cycles, each at every phase against the 8-cycle sampling pulse. This separates pulses that cover zero, one, two or more sampling edges. For each pulse the bench checks the exact cycle of the fall and of the recovery, which catches off-by-one acceptance and a missing synchroniser stage. Back-to-back trials that each cover one sampling edge show whether the pending count really clears between them. Short and long pulses are also run with filt_en low, and with evt_mode low and filt_en high. These trials show the bypass latency and that filt_en has no effect outside event mode.

// File: rtl/evt_filt_pkg.sv
package evt_filt_pkg;
  localparam int unsigned DEF_SYNC_STAGES  = 2;
  localparam int unsigned DEF_ACCEPT_EDGES = 2;

  function automatic int unsigned cnt_width(input int unsigned edges);
    return (edges > 1) ? $clog2(edges) : 1;
  endfunction
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int unsigned STAGES = evt_filt_pkg::DEF_SYNC_STAGES,
  parameter bit          IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= IDLE;
          else        chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= IDLE;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/evt_settle.sv
module evt_settle #(
  parameter int unsigned ACCEPT_EDGES = evt_filt_pkg::DEF_ACCEPT_EDGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic lvl_in,
  output logic held
);
  localparam int unsigned CNT_W = evt_filt_pkg::cnt_width(ACCEPT_EDGES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACCEPT_EDGES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b1;
      cnt  <= '0;
    end else if (lvl_in == held) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == LAST) begin
        held <= lvl_in;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(held)); // R2
  AST_MOVE_AFTER_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(held) |-> ($past(cnt) == LAST)); // R1
  AST_MATCH_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_in == held) |=> (cnt == '0)); // R2
endmodule

// File: rtl/evt_glitch_filter.sv
module evt_glitch_filter #(
  parameter int unsigned SYNC_STAGES  = evt_filt_pkg::DEF_SYNC_STAGES,
  parameter int unsigned ACCEPT_EDGES = evt_filt_pkg::DEF_ACCEPT_EDGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_fall,
  input  logic raw_in,
  input  logic filt_en,
  input  logic evt_mode,
  output logic filt_out
);
  logic sync_lvl;
  logic settled_lvl;
  logic filt_sel;

  evt_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw_in),
    .q_out (sync_lvl)
  );

  evt_settle #(.ACCEPT_EDGES(ACCEPT_EDGES)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (samp_fall),
    .lvl_in (sync_lvl),
    .held   (settled_lvl)
  );

  assign filt_sel = filt_en & evt_mode;
  assign filt_out = filt_sel ? settled_lvl : sync_lvl;

  AST_RESET_IDLE_HIGH: assert property (@(posedge clk)
    !rst_n |=> filt_out); // R6
  AST_FILTERED_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_sel && $past(filt_sel) && !$past(samp_fall)) |-> $stable(filt_out)); // R1
endmodule

// File: tb/test_evt_glitch_filter.sv
module test_evt_glitch_filter;
  localparam int CLK_PERIOD = 10;
  localparam int SP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic samp_fall = 1'b0;
  logic raw_in = 1'b1;
  logic filt_en = 1'b0;
  logic evt_mode = 1'b0;
  logic filt_out;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int t_s = -100;
  int t_l = 0;
  int fall_at, rise_at, fall_n;
  logic prev_out = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_glitch_filter i_evt_glitch_filter (
    .clk(clk), .rst_n(rst_n), .samp_fall(samp_fall), .raw_in(raw_in),
    .filt_en(filt_en), .evt_mode(evt_mode), .filt_out(filt_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (prev_out && !filt_out) begin
      fall_n++;
      if (fall_at < 0) fall_at = cyc - 1;
    end
    if (!prev_out && filt_out && rise_at < 0) rise_at = cyc - 1;
    prev_out = filt_out;
    raw_in = !(cyc >= t_s && cyc < t_s + t_l);
    samp_fall = ((cyc % SP) == SP - 1);
    cyc++;
  endtask

  // k-th qualifying sampling pulse at or after cycle 'from' and before 'upto'
  function automatic int nth_pulse(input int from, input int upto, input int n);
    int seen = 0;
    for (int j = from; j < upto; j++) begin
      if ((j % SP) == SP - 1) begin
        seen++;
        if (seen == n) return j;
      end
    end
    return -1;
  endfunction

  task automatic trial(input int phase, input int len, input bit fen, input bit emode);
    int exp_fall, exp_rise, span;
    string tag;
    filt_en = fen;
    evt_mode = emode;
    fall_at = -1; rise_at = -1; fall_n = 0;
    t_s = cyc + 2 + phase;
    t_l = len;
    span = 2 + phase + len + 3 * SP + 4;
    if (fen && emode) begin
      exp_fall = nth_pulse(t_s + 2, t_s + 2 + len, 2);
      exp_rise = (exp_fall < 0) ? -1 : nth_pulse(t_s + len + 2, t_s + len + 4 * SP, 2);
      if (len < SP)           tag = "R3 short pulse rejected";
      else if (len >= 2 * SP) tag = "R3 long pulse passed";
      else                    tag = "R2 mid pulse by edge count";
    end else begin
      exp_fall = t_s + 1;
      exp_rise = t_s + len + 1;
      tag = fen ? "R5 filt_en ignored outside event mode" : "R4 bypass latency";
    end
    for (int i = 0; i < span; i++) step();
    check(fall_at == exp_fall, {tag, " / R1 fall cycle"}, fall_at, exp_fall);
    check(rise_at == exp_rise, {tag, " / R7 rise cycle"}, rise_at, exp_rise);
    check(fall_n == ((exp_fall < 0) ? 0 : 1), {tag, " fall count"}, fall_n, (exp_fall < 0) ? 0 : 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    raw_in = 1'b0;
    repeat (3) @(negedge clk);
    check(filt_out == 1'b1, "R6 reset output high with raw low", int'(filt_out), 1);
    raw_in = 1'b1;
    @(negedge clk);
    check(filt_out == 1'b1, "R6 reset output high", int'(filt_out), 1);
    rst_n = 1'b1;
    repeat (2 * SP) step();
    check(filt_out == 1'b1, "R6 idle high after reset", int'(filt_out), 1);

    for (int ph = 0; ph < SP; ph++)
      for (int len = 1; len <= 24; len++)
        trial(ph, len, 1'b1, 1'b1);

    for (int ph = 0; ph < 4; ph++) begin
      trial(ph, 1, 1'b0, 1'b1);
      trial(ph, 5, 1'b0, 1'b1);
      trial(ph, 1, 1'b1, 1'b0);
      trial(ph, 5, 1'b1, 1'b0);
      trial(ph, 3, 1'b0, 1'b0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule